// File: doc/BRIEF.md
# Packed Saturating Byte Absolute-Value Unit

This block is one execution slice of a SIMD datapath. It takes a single 64-bit source operand and treats its low 32 bits as four signed Q7 fractional bytes. For each byte it forms the absolute value. The one value with no positive counterpart (-1.0, encoded 0x80) is clamped to the largest positive value, 0x7F. The four byte results fill the low word of a 64-bit result, and the upper word is filled with the sign of the top byte result. Whenever any byte was clamped, a sticky overflow bit is set in a local 32-bit DSP control/status register.

The slice contains its own instruction decoder. It accepts the operation in two 32-bit forms, a compact one and a standard one. It supplies the source register index combinationally, so a register file can be read in the same cycle. One cycle after issue it returns the result, a register-write enable and a destination index. An instruction that is not recognised, or that arrives while the DSP enable is low, raises an exception instead. In that case no register write and no flag update take place. Software may overwrite the whole control register through a dedicated write port.

Top module: `qb_abs_sat_unit`

## Requirements
- R1: Each of the four byte lanes (bits 7:0, 15:8, 23:16, 31:24 of `src_data`) is processed on its own, and `src_data[63:32]` has no effect on any output.
- R2: A lane holding 0x80 yields 0x7F.
- R3: A lane with bit 7 set and a value other than 0x80 yields its two's-complement negation. A lane with bit 7 clear passes through unchanged.
- R4: Result bits 31:0 hold the lane results in lane order. Bits 63:32 each equal bit 31 of the result.
- R5: An accepted instruction with any lane equal to 0x80 sets bit 20 of `ctrl_reg` at the issuing clock edge. No operation of the unit clears that bit.
- R6: `ctrl_reg` resets synchronously to zero. A software write (`sw_ctrl_we`) loads `sw_ctrl_wdata`, and it takes priority over a sticky set in the same cycle.
- R7: Compact form: bits 31:26 = 000000, 15:6 = 0000000100, 5:0 = 111100. The destination index is bits 25:21 and the source index is bits 20:16.
- R8: Standard form: bits 31:26 = 011111, 25:21 = 00000, 10:6 = 00001, 5:0 = 010010. The source index is bits 20:16 and the destination index is bits 15:11.
- R9: An issued word that matches neither form raises `out_exc_reserved` one cycle later, with no register write and no flag update. This exception takes priority over the DSP-disabled exception.
- R10: A recognised instruction issued while `dsp_en` is low raises `out_exc_dsp_off` one cycle later, with no register write and no flag update.
- R11: An accepted instruction gives `out_valid` = `out_wr_en` = 1 exactly one cycle after `in_valid`, with the result and the destination index. No operand value raises an exception.
- R12: `abs_comb` presents the full 64-bit result in the same cycle as `src_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Instruction word issued this cycle |
| instr | input | 32 | Instruction word |
| src_data | input | 64 | Source operand value |
| dsp_en | input | 1 | DSP unit enabled |
| sw_ctrl_we | input | 1 | Software write of the control register |
| sw_ctrl_wdata | input | 32 | Software write data |
| src_idx | output | 5 | Decoded source register index (combinational) |
| abs_comb | output | 64 | Combinational result |
| out_valid | output | 1 | Registered result valid |
| out_result | output | 64 | Registered result |
| out_wr_en | output | 1 | Register-write enable |
| out_wr_idx | output | 5 | Destination register index |
| out_exc_reserved | output | 1 | Reserved-instruction exception |
| out_exc_dsp_off | output | 1 | DSP-disabled exception |
| ctrl_reg | output | 32 | DSP control/status register contents |

## Verification
The hardest cases to reach are those where two updates of the control register meet. One is a software write in the same cycle as a clamping instruction. The other is a clamping operand carried by a word that ends up rejected. To set these up, the bench first clears the register through the software port. It then issues a 0x80-carrying operand together with a same-cycle write, with a corrupted encoding, or with `dsp_en` low, and reads bit 20 back on `ctrl_reg`. Stickiness is shown by following a clamping instruction with a clean one and checking that the bit stays set.

// File: rtl/qbabs_pkg.sv
// Package: shared encodings and the decoded-instruction type for the
// packed byte absolute-value slice. Assumes 32-bit words, 5-bit indices.
package qbabs_pkg;

    localparam int unsigned IDX_W = 5;

    // Compact form fixed fields
    localparam logic [5:0] CMP_MAJOR = 6'b000000;
    localparam logic [9:0] CMP_MINOR = 10'b0000000100;
    localparam logic [5:0] CMP_FUNC  = 6'b111100;

    // Standard form fixed fields
    localparam logic [5:0] STD_MAJOR = 6'b011111;
    localparam logic [4:0] STD_ZERO  = 5'b00000;
    localparam logic [4:0] STD_SUBOP = 5'b00001;
    localparam logic [5:0] STD_FUNC  = 6'b010010;

    typedef struct packed {
        logic             legal;
        logic [IDX_W-1:0] dst;
        logic [IDX_W-1:0] src;
    } qb_dec_t;

endpackage

// File: rtl/qbabs_decode.sv
// Module: qbabs_decode
// Recognises the operation in its compact and standard 32-bit forms and
// extracts the source and destination register indices. Purely
// combinational; assumes at most one form can match a given word.
module qbabs_decode
    import qbabs_pkg::*;
(
    input  logic [31:0] instr,
    output qb_dec_t     dec
);

    logic is_cmp;
    logic is_std;

    // Match the fixed fields of each form
    always_comb begin
        is_cmp = (instr[31:26] == CMP_MAJOR) && (instr[15:6] == CMP_MINOR)
              && (instr[5:0] == CMP_FUNC);
        is_std = (instr[31:26] == STD_MAJOR) && (instr[25:21] == STD_ZERO)
              && (instr[10:6] == STD_SUBOP) && (instr[5:0] == STD_FUNC);
    end

    // Select index fields according to the matched form
    always_comb begin
        dec.legal = is_cmp || is_std;
        if (is_std) begin
            dec.src = instr[20:16];
            dec.dst = instr[15:11];
        end else begin
            dec.src = instr[20:16];
            dec.dst = instr[25:21];
        end
    end

    // R7 R8: the two forms are mutually exclusive
    always_comb begin
        a_r8_forms_exclusive: assert (!(is_cmp && is_std));
    end

endmodule

// File: rtl/qbabs_lane.sv
// Module: qbabs_lane
// Saturating absolute value of one signed fractional lane. The most
// negative code maps to the largest positive code; other negative codes
// are negated; non-negative codes pass through. Combinational.
module qbabs_lane #(
    parameter int unsigned LANE_W = 8
) (
    input  logic [LANE_W-1:0] lane_in,
    output logic [LANE_W-1:0] lane_out,
    output logic              lane_sat
);

    localparam logic [LANE_W-1:0] MOST_NEG = {1'b1, {(LANE_W-1){1'b0}}};
    localparam logic [LANE_W-1:0] MOST_POS = ~MOST_NEG;

    // Compute the magnitude with clamp on the most negative code
    always_comb begin
        lane_sat = (lane_in == MOST_NEG);
        if (lane_sat)
            lane_out = MOST_POS;
        else if (lane_in[LANE_W-1])
            lane_out = (~lane_in) + 1'b1;
        else
            lane_out = lane_in;
    end

    // R2 R3: magnitude is never negative
    always_comb begin
        a_r3_non_negative: assert (!lane_out[LANE_W-1]);
        a_r2_clamp: assert (!lane_sat || (lane_out == MOST_POS));
    end

endmodule

// File: rtl/qbabs_ctrl_reg.sv
// Module: qbabs_ctrl_reg
// Local DSP control/status register. Software writes load the whole
// word and win over a same-cycle sticky set of the overflow bit.
// Synchronous active-low reset to zero.
module qbabs_ctrl_reg #(
    parameter int unsigned REG_W    = 32,
    parameter int unsigned FLAG_BIT = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sw_we,
    input  logic [REG_W-1:0] sw_wdata,
    input  logic             set_flag,
    output logic [REG_W-1:0] q
);

    // Register update: reset, software write, then sticky set
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= '0;
        else if (sw_we)
            q <= sw_wdata;
        else if (set_flag)
            q[FLAG_BIT] <= 1'b1;
    end

    // R5: without a software write the flag is never cleared
    a_r5_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (q[FLAG_BIT] && !sw_we) |=> q[FLAG_BIT]);

    // R6: a software write always lands
    a_r6_sw_wins: assert property (@(posedge clk) disable iff (!rst_n)
        sw_we |=> (q == $past(sw_wdata)));

endmodule

// File: rtl/qb_abs_sat_unit.sv
// Module: qb_abs_sat_unit
// Top of the packed saturating byte absolute-value slice: decoder, lane
// array, control register and a one-stage output register. Assumes the
// register file reads src_data combinationally from src_idx.
module qb_abs_sat_unit
    import qbabs_pkg::*;
#(
    parameter int unsigned DATA_W   = 64,
    parameter int unsigned LANE_W   = 8,
    parameter int unsigned LANES    = 4,
    parameter int unsigned CTRL_W   = 32,
    parameter int unsigned FLAG_BIT = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [31:0]       instr,
    input  logic [DATA_W-1:0] src_data,
    input  logic              dsp_en,
    input  logic              sw_ctrl_we,
    input  logic [CTRL_W-1:0] sw_ctrl_wdata,
    output logic [IDX_W-1:0]  src_idx,
    output logic [DATA_W-1:0] abs_comb,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_result,
    output logic              out_wr_en,
    output logic [IDX_W-1:0]  out_wr_idx,
    output logic              out_exc_reserved,
    output logic              out_exc_dsp_off,
    output logic [CTRL_W-1:0] ctrl_reg
);

    localparam int unsigned LOW_W = LANES * LANE_W;
    localparam int unsigned HI_W  = DATA_W - LOW_W;

    qb_dec_t            dec;
    logic [LOW_W-1:0]   low_res;
    logic [LANES-1:0]   sat_vec;
    logic               accept;
    logic               any_sat;
    logic               unused_hi;

    assign unused_hi = ^src_data[DATA_W-1:LOW_W];

    qbabs_decode u_decode (
        .instr (instr),
        .dec   (dec)
    );

    assign src_idx = dec.src;

    // One saturating lane per byte of the low word
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        qbabs_lane #(.LANE_W(LANE_W)) u_lane (
            .lane_in  (src_data[g*LANE_W +: LANE_W]),
            .lane_out (low_res[g*LANE_W +: LANE_W]),
            .lane_sat (sat_vec[g])
        );
    end

    // Assemble the sign-extended result and the issue conditions
    always_comb begin
        abs_comb = {{HI_W{low_res[LOW_W-1]}}, low_res};
        any_sat  = |sat_vec;
        accept   = in_valid && dec.legal && dsp_en;
    end

    qbabs_ctrl_reg #(.REG_W(CTRL_W), .FLAG_BIT(FLAG_BIT)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .sw_we    (sw_ctrl_we),
        .sw_wdata (sw_ctrl_wdata),
        .set_flag (accept && any_sat),
        .q        (ctrl_reg)
    );

    // Output stage: result, write control and exceptions one cycle after issue
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid        <= 1'b0;
            out_wr_en        <= 1'b0;
            out_result       <= '0;
            out_wr_idx       <= '0;
            out_exc_reserved <= 1'b0;
            out_exc_dsp_off  <= 1'b0;
        end else begin
            out_valid        <= accept;
            out_wr_en        <= accept;
            out_exc_reserved <= in_valid && !dec.legal;
            out_exc_dsp_off  <= in_valid && dec.legal && !dsp_en;
            if (accept) begin
                out_result <= abs_comb;
                out_wr_idx <= dec.dst;
            end
        end
    end

    // R9 R10: no exception coexists with a write or with another exception
    a_r9_exc_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({out_valid, out_exc_reserved, out_exc_dsp_off}));

    a_r10_no_write_on_exc: assert property (@(posedge clk) disable iff (!rst_n)
        (out_exc_reserved || out_exc_dsp_off) |-> !out_wr_en);

    // R4: upper word mirrors bit 31 of the registered result
    a_r4_sign_ext: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_result[DATA_W-1:LOW_W] == {HI_W{out_result[LOW_W-1]}}));

    // R11: a valid output only follows an issue
    a_r11_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_valid) |=> !out_valid);

endmodule

// File: tb/qb_abs_sat_unit_bench.sv
`timescale 1ns/1ps
module qb_abs_sat_unit_bench;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic [31:0] instr;
    logic [63:0] src_data;
    logic        dsp_en;
    logic        sw_ctrl_we;
    logic [31:0] sw_ctrl_wdata;
    logic [4:0]  src_idx;
    logic [63:0] abs_comb;
    logic        out_valid;
    logic [63:0] out_result;
    logic        out_wr_en;
    logic [4:0]  out_wr_idx;
    logic        out_exc_reserved;
    logic        out_exc_dsp_off;
    logic [31:0] ctrl_reg;

    int errors = 0;
    int checks = 0;
    bit done   = 0;
    logic [63:0] comb_seen;

    localparam logic [31:0] FLAG = 32'h0010_0000;

    always #2.5 clk = ~clk;

    qb_abs_sat_unit u_qb_abs_sat_unit (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr),
        .src_data(src_data), .dsp_en(dsp_en), .sw_ctrl_we(sw_ctrl_we),
        .sw_ctrl_wdata(sw_ctrl_wdata), .src_idx(src_idx), .abs_comb(abs_comb),
        .out_valid(out_valid), .out_result(out_result), .out_wr_en(out_wr_en),
        .out_wr_idx(out_wr_idx), .out_exc_reserved(out_exc_reserved),
        .out_exc_dsp_off(out_exc_dsp_off), .ctrl_reg(ctrl_reg)
    );

    function automatic logic [31:0] enc_cmp(logic [4:0] dst, logic [4:0] src);
        return {6'b000000, dst, src, 10'b0000000100, 6'b111100};
    endfunction

    function automatic logic [31:0] enc_std(logic [4:0] src, logic [4:0] dst);
        return {6'b011111, 5'b00000, src, dst, 5'b00001, 6'b010010};
    endfunction

    function automatic logic [7:0] ref_lane(logic [7:0] v);
        if (v == 8'h80) return 8'h7F;
        if (v[7]) return 8'(0 - int'(v) + 256);
        return v;
    endfunction

    function automatic logic [63:0] ref_abs(logic [63:0] s);
        logic [31:0] lo;
        for (int i = 0; i < 4; i++) lo[i*8 +: 8] = ref_lane(s[i*8 +: 8]);
        return {{32{lo[31]}}, lo};
    endfunction

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Issue one word at a negedge; registered outputs are valid at the next negedge
    task automatic issue(logic [31:0] w, logic [63:0] s, logic en, logic swe, logic [31:0] swd);
        @(negedge clk);
        in_valid = 1'b1; instr = w; src_data = s; dsp_en = en;
        sw_ctrl_we = swe; sw_ctrl_wdata = swd;
        #1 comb_seen = abs_comb;
        @(negedge clk);
        in_valid = 1'b0; sw_ctrl_we = 1'b0; instr = 32'h0;
    endtask

    task automatic sw_write(logic [31:0] d);
        @(negedge clk);
        sw_ctrl_we = 1'b1; sw_ctrl_wdata = d;
        @(negedge clk);
        sw_ctrl_we = 1'b0;
    endtask

    task automatic t_reset;
        chk("R6 reset ctrl", {32'h0, ctrl_reg}, 64'h0);
        chk("R11 reset valid", {63'h0, out_valid}, 64'h0);
        chk("R9 reset exc", {62'h0, out_exc_reserved, out_exc_dsp_off}, 64'h0);
    endtask

    task automatic t_sweep;
        for (int v = 0; v < 256; v++) begin
            logic [63:0] s;
            s = {32'hDEAD_BEEF ^ 32'(v * 7), 8'(v), 8'(v ^ 8'h5A), 8'(255 - v), 8'(v + 8'h80)};
            issue(enc_cmp(5'd3, 5'd9), s, 1'b1, 1'b0, 32'h0);
            chk("R1 R2 R3 R4 sweep", out_result, ref_abs(s));
            if (v == 0 || v == 128 || v == 255) chk("R12 comb", comb_seen, ref_abs(s));
        end
    endtask

    task automatic t_upper_ignored;
        logic [63:0] r1;
        issue(enc_cmp(5'd1, 5'd2), 64'h0000_0000_81FF_7F01, 1'b1, 1'b0, 32'h0);
        r1 = out_result;
        issue(enc_cmp(5'd1, 5'd2), 64'hFFFF_FFFF_81FF_7F01, 1'b1, 1'b0, 32'h0);
        chk("R1 upper ignored", out_result, r1);
        chk("R3 values", r1, 64'h0000_0000_7F01_7F01);
    endtask

    task automatic t_flag_sticky;
        sw_write(32'h0);
        issue(enc_cmp(5'd4, 5'd5), 64'h0000_0000_7F81_FF00, 1'b1, 1'b0, 32'h0);
        chk("R5 no clamp no flag", {32'h0, ctrl_reg}, 64'h0);
        issue(enc_cmp(5'd4, 5'd5), 64'h0000_0000_0080_0000, 1'b1, 1'b0, 32'h0);
        chk("R5 clamp sets flag", {32'h0, ctrl_reg}, {32'h0, FLAG});
        chk("R2 clamp value", out_result, 64'h0000_0000_007F_0000);
        issue(enc_cmp(5'd4, 5'd5), 64'h0000_0000_0102_0304, 1'b1, 1'b0, 32'h0);
        chk("R5 sticky", {32'h0, ctrl_reg}, {32'h0, FLAG});
    endtask

    task automatic t_sw_priority;
        sw_write(32'h0);
        issue(enc_cmp(5'd4, 5'd5), 64'h0000_0000_8000_0000, 1'b1, 1'b1, 32'h0000_00A5);
        chk("R6 sw write wins", {32'h0, ctrl_reg}, 64'h0000_0000_0000_00A5);
        chk("R11 still written", {63'h0, out_wr_en}, 64'h1);
    endtask

    task automatic t_decode;
        @(negedge clk); instr = enc_cmp(5'd17, 5'd22); #1;
        chk("R7 src idx", {59'h0, src_idx}, 64'd22);
        issue(enc_cmp(5'd17, 5'd22), 64'h0, 1'b1, 1'b0, 32'h0);
        chk("R7 dst idx", {59'h0, out_wr_idx}, 64'd17);
        chk("R11 valid wr", {62'h0, out_valid, out_wr_en}, 64'h3);
        @(negedge clk); instr = enc_std(5'd12, 5'd30); #1;
        chk("R8 src idx", {59'h0, src_idx}, 64'd12);
        issue(enc_std(5'd12, 5'd30), 64'h0000_0000_F000_00C0, 1'b1, 1'b0, 32'h0);
        chk("R8 dst idx", {59'h0, out_wr_idx}, 64'd30);
        chk("R8 result", out_result, 64'h0000_0000_1000_0040);
        @(negedge clk);
        chk("R11 one cycle only", {63'h0, out_valid}, 64'h0);
    endtask

    task automatic t_reserved;
        sw_write(32'h0);
        issue(enc_std(5'd1, 5'd2) | 32'h0020_0000, 64'h80, 1'b1, 1'b0, 32'h0);
        chk("R9 exc raised", {62'h0, out_exc_reserved, out_exc_dsp_off}, 64'h2);
        chk("R9 no write", {62'h0, out_valid, out_wr_en}, 64'h0);
        chk("R9 no flag", {32'h0, ctrl_reg}, 64'h0);
        issue(enc_cmp(5'd1, 5'd2) ^ 32'h0000_0040, 64'h80, 1'b0, 1'b0, 32'h0);
        chk("R9 priority over dsp off", {62'h0, out_exc_reserved, out_exc_dsp_off}, 64'h2);
    endtask

    task automatic t_dsp_off;
        sw_write(32'h0);
        issue(enc_cmp(5'd6, 5'd7), 64'h8080_8080, 1'b0, 1'b0, 32'h0);
        chk("R10 exc raised", {62'h0, out_exc_reserved, out_exc_dsp_off}, 64'h1);
        chk("R10 no write", {62'h0, out_valid, out_wr_en}, 64'h0);
        chk("R10 no flag", {32'h0, ctrl_reg}, 64'h0);
        issue(enc_cmp(5'd6, 5'd7), 64'h8080_8080, 1'b1, 1'b0, 32'h0);
        chk("R11 no exc on operand", {62'h0, out_exc_reserved, out_exc_dsp_off}, 64'h0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; in_valid = 1'b0; instr = 32'h0; src_data = 64'h0;
        dsp_en = 1'b1; sw_ctrl_we = 1'b0; sw_ctrl_wdata = 32'h0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_sweep();
        t_upper_ignored();
        t_flag_sticky();
        t_sw_priority();
        t_decode();
        t_reserved();
        t_dsp_off();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule